// File: doc/BRIEF.md
# Message Interrupt Identifier Prioritizer

This block sits between a set of message objects, the protocol core of a message controller and the host interrupt line. It keeps one interrupt-pending bit per message object and one status-change flag for the core. From these it builds a single identifier value that software reads to learn which source to service first, and one interrupt line towards the host.

A core status update that the software enables raises the status flag. That flag is reported with a fixed code placed above every message object. Software clears the flag by reading the status register. Object flags are raised by set pulses from the object logic and dropped by clear pulses from the service path. Each time a flag drops, the identifier moves on to the next pending source.

Top module: `msg_irq_prio`

## Requirements
- R1: After a synchronous reset `int_id` is 0 and `int_line` is 0. `int_id` reads 0 whenever no object flag and no status flag is pending.
- R2: While the status flag is pending, `int_id` equals 0x8000 (bit ID_W-1 set, all other bits clear), whatever object flags are pending.
- R3: With no status flag pending, `int_id` equals k+1, where k is the lowest index whose object pending bit is set. Object bit 0 reads as 1 and object bit 31 reads as 32.
- R4: When the reporting object's pending bit is cleared through `obj_clr`, `int_id` moves to the next-lowest pending object. If no object is left, it moves to 0.
- R5: Only a `stat_rd` pulse clears the status flag. An `obj_clr` pulse, even on all objects, leaves the status flag pending.
- R6: `core_err_upd` raises the status flag only when `err_ie` is 1. `core_stat_upd` raises it only when `stat_ie` is 1. An update pulse that its enable does not permit has no effect on `int_id`. A core update raises the flag even if the status contents are unchanged.
- R7: If `obj_set` and `obj_clr` are both high for the same object in the same cycle, that object's pending bit ends up set.
- R8: If `stat_rd` arrives in the same cycle as a permitted core update, the status flag stays pending.
- R9: `int_line` is 1 only when the registered identifier is nonzero and `glob_ie` was 1 at the previous edge. `int_id` keeps tracking pending sources while `glob_ie` is 0.
- R10: A set pulse sampled at clock edge E changes the pending state at E. `int_id` and `int_line` show that change at edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_set | input | NUM_OBJ | Per-object pending set pulses |
| obj_clr | input | NUM_OBJ | Per-object pending clear pulses |
| core_err_upd | input | 1 | Core error-state update strobe |
| core_stat_upd | input | 1 | Core status update strobe |
| err_ie | input | 1 | Enable for error-update interrupts |
| stat_ie | input | 1 | Enable for status-update interrupts |
| glob_ie | input | 1 | Global interrupt line enable |
| stat_rd | input | 1 | Software read of the status register |
| int_id | output | ID_W | Identifier of the highest-priority pending source |
| int_line | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with its defaults: 32 objects and a 16-bit identifier. This makes both ends of the object range reachable, with object bit 0 reading as 1 and object bit 31 reading as 32. The status code in the top identifier bit then cannot collide with any object number. Sequences that clear several pending objects one at a time show the identifier stepping across the whole range. They also check that it ends at zero.

// File: rtl/mipr_pkg.sv
package mipr_pkg;

  // core-side update strobes
  typedef struct packed {
    logic err_upd;
    logic stat_upd;
  } core_upd_t;

  // software enables for the two update kinds
  typedef struct packed {
    logic err_ie;
    logic stat_ie;
  } upd_en_t;

  // an update raises the status flag only when its own enable allows it
  function automatic logic upd_raises(core_upd_t upd, upd_en_t en);
    return (upd.err_upd & en.err_ie) | (upd.stat_upd & en.stat_ie);
  endfunction

endpackage

// File: rtl/mipr_pend_bank.sv
module mipr_pend_bank #(
  parameter int unsigned NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] set_i,
  input  logic [NUM_OBJ-1:0] clr_i,
  output logic [NUM_OBJ-1:0] pend_o
);

  logic [NUM_OBJ-1:0] pend_q;

  // one flop per object; a set in the same cycle as a clear wins
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    always_ff @(posedge clk) begin
      if (rst)
        pend_q[g] <= 1'b0;
      else if (set_i[g])
        pend_q[g] <= 1'b1;
      else if (clr_i[g])
        pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/mipr_stat_flag.sv
module mipr_stat_flag (
  input  logic clk,
  input  logic rst,
  input  logic raise_i,
  input  logic rd_i,
  output logic flag_o
);

  logic flag_q;

  // a new raise outranks a read in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b0;
    else if (raise_i)
      flag_q <= 1'b1;
    else if (rd_i)
      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/mipr_prio_enc.sv
module mipr_prio_enc #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned ID_W    = 16
) (
  input  logic [NUM_OBJ-1:0] pend_i,
  output logic [ID_W-1:0]    num_o
);

  // scan from the top so the lowest set index is written last
  always_comb begin
    num_o = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend_i[i])
        num_o = ID_W'(i + 1);
    end
  end

endmodule

// File: rtl/msg_irq_prio.sv
module msg_irq_prio #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned ID_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] obj_set,
  input  logic [NUM_OBJ-1:0] obj_clr,
  input  logic               core_err_upd,
  input  logic               core_stat_upd,
  input  logic               err_ie,
  input  logic               stat_ie,
  input  logic               glob_ie,
  input  logic               stat_rd,
  output logic [ID_W-1:0]    int_id,
  output logic               int_line
);

  import mipr_pkg::*;

  localparam logic [ID_W-1:0] STAT_CODE = ID_W'(1) << (ID_W - 1);

  logic [NUM_OBJ-1:0] pend_vec;
  logic               stat_pend;
  logic               raise;
  logic [ID_W-1:0]    obj_num;
  logic [ID_W-1:0]    id_next;
  logic [ID_W-1:0]    id_q;
  logic               line_q;
  core_upd_t          upd;
  upd_en_t            upd_en;

  assign upd    = '{err_upd: core_err_upd, stat_upd: core_stat_upd};
  assign upd_en = '{err_ie: err_ie, stat_ie: stat_ie};
  assign raise  = upd_raises(upd, upd_en);

  mipr_pend_bank #(.NUM_OBJ(NUM_OBJ)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .set_i (obj_set),
    .clr_i (obj_clr),
    .pend_o(pend_vec)
  );

  mipr_stat_flag u_stat (
    .clk    (clk),
    .rst    (rst),
    .raise_i(raise),
    .rd_i   (stat_rd),
    .flag_o (stat_pend)
  );

  mipr_prio_enc #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_enc (
    .pend_i(pend_vec),
    .num_o (obj_num)
  );

  assign id_next = stat_pend ? STAT_CODE : obj_num;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q   <= '0;
      line_q <= 1'b0;
    end else begin
      id_q   <= id_next;
      line_q <= glob_ie & (id_next != '0);
    end
  end

  assign int_id   = id_q;
  assign int_line = line_q;

endmodule

// File: rtl/mipr_checker.sv
module mipr_checker #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned ID_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OBJ-1:0] obj_set,
  input logic               core_err_upd,
  input logic               core_stat_upd,
  input logic               err_ie,
  input logic               stat_ie,
  input logic               glob_ie,
  input logic               stat_rd,
  input logic [NUM_OBJ-1:0] pend_vec,
  input logic               stat_pend,
  input logic [ID_W-1:0]    int_id,
  input logic               int_line
);

  localparam logic [ID_W-1:0] CODE = ID_W'(1) << (ID_W - 1);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (pend_vec == '0 && !stat_pend) |=> (int_id == '0));

  assert_stat_top_R2: assert property (@(posedge clk) disable iff (rst)
    stat_pend |=> (int_id == CODE));

  assert_obj_range_R3: assert property (@(posedge clk) disable iff (rst)
    (int_id != CODE) |-> (int_id <= ID_W'(NUM_OBJ)));

  assert_rd_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_pend && stat_rd && !core_err_upd && !core_stat_upd) |=> !stat_pend);

  assert_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (!stat_pend && !(core_err_upd && err_ie) && !(core_stat_upd && stat_ie))
      |=> !stat_pend);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|obj_set) |=> ((pend_vec & $past(obj_set)) == $past(obj_set)));

  assert_race_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && core_stat_upd && stat_ie) |=> stat_pend);

  assert_line_nz_R9: assert property (@(posedge clk) disable iff (rst)
    int_line |-> (int_id != '0));

  assert_line_ie_R9: assert property (@(posedge clk) disable iff (rst)
    int_line |-> $past(glob_ie));

endmodule

bind msg_irq_prio mipr_checker #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .obj_set      (obj_set),
  .core_err_upd (core_err_upd),
  .core_stat_upd(core_stat_upd),
  .err_ie       (err_ie),
  .stat_ie      (stat_ie),
  .glob_ie      (glob_ie),
  .stat_rd      (stat_rd),
  .pend_vec     (pend_vec),
  .stat_pend    (stat_pend),
  .int_id       (int_id),
  .int_line     (int_line)
);

// File: tb/msg_irq_prio_bench.sv
module msg_irq_prio_bench;

  localparam int unsigned N  = 32;
  localparam int unsigned IW = 16;
  localparam logic [IW-1:0] SCODE = 16'h8000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  obj_set = '0;
  logic [N-1:0]  obj_clr = '0;
  logic          core_err_upd = 1'b0;
  logic          core_stat_upd = 1'b0;
  logic          err_ie = 1'b0;
  logic          stat_ie = 1'b0;
  logic          glob_ie = 1'b0;
  logic          stat_rd = 1'b0;
  logic [IW-1:0] int_id;
  logic          int_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  msg_irq_prio #(.NUM_OBJ(N), .ID_W(IW)) u_msg_irq_prio (
    .clk, .rst, .obj_set, .obj_clr, .core_err_upd, .core_stat_upd,
    .err_ie, .stat_ie, .glob_ie, .stat_rd, .int_id, .int_line
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_id(string req, logic [IW-1:0] exp);
    checks++;
    if (int_id !== exp) begin
      fails++;
      $display("FAIL %s int_id actual=%h expected=%h", req, int_id, exp);
    end
  endtask

  task automatic chk_line(string req, logic exp);
    checks++;
    if (int_line !== exp) begin
      fails++;
      $display("FAIL %s int_line actual=%b expected=%b", req, int_line, exp);
    end
  endtask

  // pulse set bits; one edge loads pending, the next loads the identifier
  task automatic set_objs(logic [N-1:0] m);
    obj_set = m; tick(); obj_set = '0; tick();
  endtask

  task automatic clr_objs(logic [N-1:0] m);
    obj_clr = m; tick(); obj_clr = '0; tick();
  endtask

  task automatic read_stat();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk_id("R1", '0);
    chk_line("R1", 1'b0);
  endtask

  task automatic t_latency();
    obj_set = 32'h0000_0020; tick(); obj_set = '0;
    chk_id("R10", '0);           // pending loaded, identifier not yet
    tick();
    chk_id("R10", 16'd6);        // R3: bit 5 -> 6
    clr_objs(32'h0000_0020);
    chk_id("R1", '0);
  endtask

  task automatic t_order();
    set_objs(32'h8000_0208);
    chk_id("R3", 16'd4);
    clr_objs(32'h0000_0008);
    chk_id("R4", 16'd10);
    clr_objs(32'h0000_0200);
    chk_id("R4", 16'd32);
    clr_objs(32'h8000_0000);
    chk_id("R4", '0);
    set_objs(32'h0000_0001);
    chk_id("R3", 16'd1);
    clr_objs(32'h0000_0001);
  endtask

  task automatic t_status();
    set_objs(32'h0000_0001);
    stat_ie = 1'b1;
    core_stat_upd = 1'b1; tick(); core_stat_upd = 1'b0; tick();
    chk_id("R2", SCODE);
    clr_objs('1);                // clear of all objects leaves the status flag
    chk_id("R5", SCODE);
    set_objs(32'h0000_0004);
    read_stat();
    chk_id("R5", 16'd3);
    clr_objs(32'h0000_0004);
    chk_id("R1", '0);
    stat_ie = 1'b0;
  endtask

  task automatic t_enables();
    err_ie = 1'b1; stat_ie = 1'b0;
    core_stat_upd = 1'b1; tick(); core_stat_upd = 1'b0; tick();
    chk_id("R6", '0);
    core_err_upd = 1'b1; tick(); core_err_upd = 1'b0; tick();
    chk_id("R6", SCODE);
    read_stat();
    chk_id("R6", '0);
    err_ie = 1'b0; stat_ie = 1'b1;
    core_err_upd = 1'b1; tick(); core_err_upd = 1'b0; tick();
    chk_id("R6", '0);
    stat_ie = 1'b0;
  endtask

  task automatic t_set_wins();
    obj_set = 32'h0000_0080; obj_clr = 32'h0000_0080; tick();
    obj_set = '0; obj_clr = '0; tick();
    chk_id("R7", 16'd8);
    clr_objs(32'h0000_0080);
    chk_id("R7", '0);
  endtask

  task automatic t_race();
    stat_ie = 1'b1;
    core_stat_upd = 1'b1; tick(); core_stat_upd = 1'b0; tick();
    chk_id("R8", SCODE);
    core_stat_upd = 1'b1; stat_rd = 1'b1; tick();
    core_stat_upd = 1'b0; stat_rd = 1'b0; tick();
    chk_id("R8", SCODE);
    read_stat();
    chk_id("R8", '0);
    stat_ie = 1'b0;
  endtask

  task automatic t_line();
    glob_ie = 1'b0;
    set_objs(32'h0000_0004);
    chk_id("R9", 16'd3);
    chk_line("R9", 1'b0);
    glob_ie = 1'b1; tick();
    chk_line("R9", 1'b1);
    glob_ie = 1'b0; tick();
    chk_line("R9", 1'b0);
    chk_id("R9", 16'd3);
    glob_ie = 1'b1;
    clr_objs(32'h0000_0004);
    chk_id("R9", '0);
    chk_line("R9", 1'b0);
    glob_ie = 1'b0;
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_latency();
    t_order();
    t_status();
    t_enables();
    t_set_wins();
    t_race();
    t_line();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule